// File: doc/BRIEF.md
# DMA Request Input Stage

This block collects the transfer requests that peripherals raise toward a DMA controller and presents one merged request vector for each kind of request. There are four kinds (burst, single, last burst, last single), and each kind has one line per source. Each source has one control bit that decides how its lines enter the block. With the bit clear, the source's lines pass through a two-flop synchronizer, which suits peripherals clocked from another domain. With the bit set, the lines go straight through, which gives the lowest latency for peripherals on the controller's own clock.

Software can also raise requests. Each request kind has a register of sticky bits. Writing a one sets a bit, and writing a zero leaves it alone. A bit stays set until the controller sends a one-cycle completion strobe for that source and that kind. Reading a request register returns the merged view, which is the software bit OR the peripheral line after its synchronizer or bypass. Arbitration between channels and the acknowledge back to the peripherals are handled elsewhere.

Top module: `dma_req_stage`

## Requirements
- R1: After reset all software request bits, all bypass-control bits and all four merged request outputs are zero.
- R2: With a source's bypass bit at 0, a change on its peripheral line reaches the merged output after exactly two rising clock edges, and not after one.
- R3: With a source's bypass bit at 1, its peripheral lines reach the merged output in the same cycle, with no clock edge in between.
- R4: A write with `wr_sel` 0, 1, 2 or 3 (burst, single, last burst, last single) sets every software bit of that kind whose data bit is 1. Data bits that are 0 leave the stored bits unchanged.
- R5: A completion strobe (`done_type` 0..3 coded as in R4, `done_src` the source index) clears only the software bit of that kind and source. All other bits keep their value.
- R6: When a software set and a completion clear hit the same bit in the same cycle, the bit ends up set.
- R7: Reading `rd_sel` 0..3 returns the merged request vector of that kind, which is the software bits OR the peripheral lines after the synchronizer or bypass.
- R8: Writing `wr_sel` 4 loads the per-source bypass bits, and `rd_sel` 4 reads them back. Each bit affects only its own source, and it affects all four request kinds of that source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_burst | input | NSRC | Peripheral burst request lines |
| hw_single | input | NSRC | Peripheral single request lines |
| hw_lburst | input | NSRC | Peripheral last-burst request lines |
| hw_lsingle | input | NSRC | Peripheral last-single request lines |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write target: 0..3 software kinds, 4 bypass bits |
| wr_data | input | NSRC | Write data |
| rd_sel | input | 3 | Read target: 0..3 merged kinds, 4 bypass bits |
| rd_data | output | NSRC | Read data |
| done_vld | input | 1 | Completion strobe, one cycle |
| done_type | input | 2 | Request kind being completed |
| done_src | input | log2(NSRC) | Source being completed |
| req_burst | output | NSRC | Merged burst requests |
| req_single | output | NSRC | Merged single requests |
| req_lburst | output | NSRC | Merged last-burst requests |
| req_lsingle | output | NSRC | Merged last-single requests |

## Verification
A sticky bit that is lost or stuck shows on the merged output and in the readback on the cycle after the write or completion that should have changed it. A completion decoded to the wrong kind or source appears as a bit in a neighbouring vector that stays high. A synchronizer that is one flop short, or a bypass that is wired the wrong way round, moves a request edge by one or two cycles. The bench therefore samples each merged output at the first edge, the second edge and in the same cycle, so such a fault appears within two clocks of the stimulus.

// File: rtl/dma_req_stage.sv
module dma_req_stage #(
  parameter int NSRC = 16,
  localparam int SW = $clog2(NSRC),
  localparam int NTYPE = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] hw_burst,
  input  logic [NSRC-1:0] hw_single,
  input  logic [NSRC-1:0] hw_lburst,
  input  logic [NSRC-1:0] hw_lsingle,
  input  logic            wr_en,
  input  logic [2:0]      wr_sel,
  input  logic [NSRC-1:0] wr_data,
  input  logic [2:0]      rd_sel,
  output logic [NSRC-1:0] rd_data,
  input  logic            done_vld,
  input  logic [1:0]      done_type,
  input  logic [SW-1:0]   done_src,
  output logic [NSRC-1:0] req_burst,
  output logic [NSRC-1:0] req_single,
  output logic [NSRC-1:0] req_lburst,
  output logic [NSRC-1:0] req_lsingle
);

  logic [NSRC-1:0]       byp_q;
  logic [NTYPE*NSRC-1:0] hw_all, s1_q, s2_q, soft_q, req_all;

  assign hw_all = {hw_lsingle, hw_lburst, hw_single, hw_burst};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byp_q <= '0;
      s1_q  <= '0;
      s2_q  <= '0;
    end else begin
      s1_q <= hw_all;
      s2_q <= s1_q;
      if (wr_en && wr_sel == 3'd4) byp_q <= wr_data;
    end
  end

  for (genvar t = 0; t < NTYPE; t++) begin : g_kind
    logic [NSRC-1:0] set_v, clr_v, path;

    assign set_v = (wr_en && wr_sel == 3'(t)) ? wr_data : '0;
    assign clr_v = (done_vld && done_type == 2'(t)) ? (NSRC'(1) << done_src) : '0;
    assign path  = (byp_q & hw_all[t*NSRC +: NSRC]) | (~byp_q & s2_q[t*NSRC +: NSRC]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) soft_q[t*NSRC +: NSRC] <= '0;
      else        soft_q[t*NSRC +: NSRC] <= (soft_q[t*NSRC +: NSRC] & ~clr_v) | set_v;
    end

    assign req_all[t*NSRC +: NSRC] = path | soft_q[t*NSRC +: NSRC];
  end

  assign req_burst   = req_all[0*NSRC +: NSRC];
  assign req_single  = req_all[1*NSRC +: NSRC];
  assign req_lburst  = req_all[2*NSRC +: NSRC];
  assign req_lsingle = req_all[3*NSRC +: NSRC];

  always_comb begin
    case (rd_sel)
      3'd0:    rd_data = req_burst;
      3'd1:    rd_data = req_single;
      3'd2:    rd_data = req_lburst;
      3'd3:    rd_data = req_lsingle;
      3'd4:    rd_data = byp_q;
      default: rd_data = '0;
    endcase
  end

endmodule

// File: rtl/dma_req_stage_chk.sv
module dma_req_stage_chk #(
  parameter int NSRC = 16,
  localparam int SW = $clog2(NSRC)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NSRC-1:0]   hw_burst,
  input logic              wr_en,
  input logic [2:0]        wr_sel,
  input logic [NSRC-1:0]   wr_data,
  input logic              done_vld,
  input logic [1:0]        done_type,
  input logic [SW-1:0]     done_src,
  input logic [NSRC-1:0]   req_burst,
  input logic [NSRC-1:0]   req_single,
  input logic [NSRC-1:0]   byp_q,
  input logic [4*NSRC-1:0] soft_q
);

  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  AST_SYNC_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3) |-> ((~byp_q & $past(hw_burst, 2) & ~req_burst) == '0)); // R2

  AST_BYPASS_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((byp_q & hw_burst & ~req_burst) == '0)); // R3

  AST_SW_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd1) |=> ((req_single & $past(wr_data)) == $past(wr_data))); // R4

  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_vld && !(wr_en && wr_sel == {1'b0, done_type}))
      |=> !soft_q[$past(done_type) * NSRC + $past(done_src)]); // R5

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (done_vld && done_type == 2'd0 && wr_en && wr_sel == 3'd0 && wr_data[done_src])
      |=> req_burst[$past(done_src)]); // R6

endmodule

bind dma_req_stage dma_req_stage_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .hw_burst(hw_burst), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_data(wr_data), .done_vld(done_vld), .done_type(done_type), .done_src(done_src),
  .req_burst(req_burst), .req_single(req_single), .byp_q(byp_q), .soft_q(soft_q)
);

// File: tb/tb_dma_req_stage.sv
module tb_dma_req_stage;
  localparam int NSRC = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NSRC-1:0] hw_burst = '0, hw_single = '0, hw_lburst = '0, hw_lsingle = '0;
  logic wr_en = 1'b0, done_vld = 1'b0;
  logic [2:0] wr_sel = '0, rd_sel = '0;
  logic [NSRC-1:0] wr_data = '0, rd_data;
  logic [1:0] done_type = '0;
  logic [3:0] done_src = '0;
  logic [NSRC-1:0] req_burst, req_single, req_lburst, req_lsingle;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  dma_req_stage #(.NSRC(NSRC)) dut (.*);

  task automatic chk(string req, logic [NSRC-1:0] act, logic [NSRC-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] sel, output logic [NSRC-1:0] v);
    rd_sel = sel; #1; v = rd_data;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [NSRC-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic done(input logic [1:0] ty, input logic [3:0] src);
    @(negedge clk); done_vld = 1'b1; done_type = ty; done_src = src;
    @(negedge clk); done_vld = 1'b0;
  endtask

  task automatic t_reset();
    logic [NSRC-1:0] v;
    chk("R1 burst out", req_burst, '0);
    chk("R1 lsingle out", req_lsingle, '0);
    for (int s = 0; s < 5; s++) begin
      rd(3'(s), v);
      chk("R1 readback", v, '0);
    end
  endtask

  task automatic t_sync();
    @(negedge clk); hw_single = 16'h0008;
    @(negedge clk); chk("R2 one edge", req_single, '0);
    @(negedge clk); chk("R2 two edges", req_single, 16'h0008);
    hw_single = '0;
    @(negedge clk); chk("R2 fall one edge", req_single, 16'h0008);
    @(negedge clk); chk("R2 fall two edges", req_single, '0);
  endtask

  task automatic t_bypass();
    logic [NSRC-1:0] v;
    wr(3'd4, 16'h0010);
    rd(3'd4, v); chk("R8 bypass readback", v, 16'h0010);
    hw_burst = 16'h0011; hw_lsingle = 16'h0010; #1;
    chk("R3 bypass burst same cycle", req_burst, 16'h0010);
    chk("R8 bypass lsingle same cycle", req_lsingle, 16'h0010);
    @(negedge clk); @(negedge clk);
    chk("R8 other source still synced", req_burst, 16'h0011);
    hw_burst = '0; hw_lsingle = '0; #1;
    chk("R3 bypass drop", req_burst, 16'h0001);
    wr(3'd4, '0);
    @(negedge clk); @(negedge clk);
    chk("R8 bypass cleared idle", req_burst, '0);
  endtask

  task automatic t_swset();
    logic [NSRC-1:0] v;
    wr(3'd2, 16'h8001);
    rd(3'd2, v); chk("R4 set lburst", v, 16'h8001);
    wr(3'd2, 16'h0000);
    rd(3'd2, v); chk("R4 zero write no effect", v, 16'h8001);
    wr(3'd2, 16'h0100);
    rd(3'd2, v); chk("R4 accumulate", v, 16'h8101);
    chk("R4 other kind untouched", req_burst, '0);
  endtask

  task automatic t_clear();
    logic [NSRC-1:0] v;
    wr(3'd3, 16'h0002);
    done(2'd2, 4'd15);
    rd(3'd2, v); chk("R5 clear src15 lburst", v, 16'h0101);
    done(2'd3, 4'd0);
    rd(3'd3, v); chk("R5 wrong src no clear", v, 16'h0002);
    rd(3'd2, v); chk("R5 wrong kind no clear", v, 16'h0101);
    done(2'd2, 4'd0); done(2'd2, 4'd8); done(2'd3, 4'd1);
    rd(3'd2, v); chk("R5 lburst empty", v, '0);
    rd(3'd3, v); chk("R5 lsingle empty", v, '0);
  endtask

  task automatic t_setwins();
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'd0; wr_data = 16'h0004;
    done_vld = 1'b1; done_type = 2'd0; done_src = 4'd2;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; done_vld = 1'b0;
    chk("R6 set wins", req_burst, 16'h0004);
    done(2'd0, 4'd2);
    chk("R6 later clear", req_burst, '0);
  endtask

  task automatic t_merge();
    logic [NSRC-1:0] v;
    wr(3'd1, 16'h0001);
    hw_single = 16'h0100;
    @(negedge clk); @(negedge clk);
    rd(3'd1, v); chk("R7 merged single", v, 16'h0101);
    done(2'd1, 4'd0);
    rd(3'd1, v); chk("R7 hw only remains", v, 16'h0100);
    hw_single = '0;
    @(negedge clk); @(negedge clk);
    rd(3'd1, v); chk("R7 all quiet", v, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1; t_reset();
    rst_n = 1'b1;
    t_sync();
    t_bypass();
    t_swset();
    t_clear();
    t_setwins();
    t_merge();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule